// File: doc/BRIEF.md
# Monochrome Raster-Op Block Transfer Engine

This block holds a one-bit-per-pixel plane in an internal word-addressed memory and moves 16-bit words within it. Each word that is moved is aligned by a two-word funnel shifter and merged with the word already at the destination under a 4-bit raster operation. A per-bit protect mask then decides which destination bits may change. A small register space sets the operating mode, the shift, the source selection, the raster operation, the mask and the upper destination address bits. The pixel at the most significant bit of a word is the leftmost pixel.

The host walks the rectangle. In blit or vector mode, every write to memory space is one transfer step. The bus address names the source word, and the bus data gives the low part of the destination word address. The engine stalls the bus for one cycle while it reads and rewrites the destination. In blit mode a read from memory space primes the shifter, so the first word of a row can be staged ahead of the transfer that needs it. In any other mode the memory behaves as a plain 16-bit RAM.

Top module: `mono_blit_engine`

## Requirements
- R1: After reset, all six registers read 0, `bus_stall` and `bus_rvalid` are low, and the held source word inside the shifter is 0. Mode code 000 behaves as normal mode.
- R2: In normal mode (mode code neither 100 nor 010), a memory-space write stores `bus_wdata` at `bus_addr` with no stall. In any mode, a memory-space read holds `bus_stall` high in the cycle after acceptance and presents the word with `bus_rvalid` high in the cycle after that.
- R3: With `bus_regsel` high, `bus_addr[2:0]` selects a register: 0 mode/shift (8 bits), 1 control (8), 2 source select (8), 3 raster op (4), 4 protect mask (16), 5 destination high (8). A write keeps only the register's width, and a read returns the value zero-extended, with `bus_rvalid` in the cycle after acceptance.
- R4: When mode bits [7:5] are 100 (blit) or 010 (vector), a memory-space write is a transfer step. The source is `bus_addr`. The destination is the low ADDR_W bits of {destination-high[1:0], `bus_wdata`}. `bus_stall` is high exactly in the cycle after acceptance, and the destination word is written at the end of that cycle.
- R5: While control bit 4 is set, result bit = raster-op code bit at index {~S,~D}. For example: code 1 gives S&D, 3 gives S, 5 gives D, 6 gives S^D, 7 gives S|D, 8 gives ~(S|D), 9 gives ~(S^D), 10 gives ~D, 12 gives ~S, 14 gives ~(S&D), 0 gives all zeros and 15 gives all ones.
- R6: While control bit 4 is clear, the result equals the source S whatever the raster-op code is.
- R7: Source-select bits [7:6] set S. Code 00 gives all ones. Code 01 gives bit 0 of the aligned word copied to all 16 bits. Codes 11 and 10 give the aligned word itself.
- R8: A protect-mask bit of 1 keeps that destination bit unchanged. A bit of 0 lets the result through.
- R9: In blit mode with control bit 5 clear (ascending), the aligned word is the low 16 bits of ({held, fetched} >> s), where s is mode bits [3:0] and mode bit 4 is ignored. After every step, held becomes the fetched word.
- R10: In blit mode with control bit 5 set (descending), the aligned word is the low 16 bits of ({fetched, held} >> s).
- R11: A memory-space read in blit mode returns the word, loads it into held and writes no memory. A read in any other mode leaves held unchanged.
- R12: In vector mode the aligned word is the fetched word with no shift applied. Mode codes other than 100 and 010 (for example 011) behave as normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus cycle request |
| bus_regsel | input | 1 | 1 = register space, 0 = plane memory space |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address, or register index in bits [2:0] |
| bus_wdata | input | WORD_W | Write data, or the low destination address during a transfer step |
| bus_stall | output | 1 | High while the engine cannot accept a cycle |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | WORD_W | Read data |

## Verification
The bench targets the shifter corner cases. These are a shift of 15, a shift field with bit 4 set (a design that used five bits would shift the data out), and shift 0 in descending order (a design that ignored direction would return the current word instead of the held one). It checks that a normal-mode read does not prime the shifter and that a priming read leaves memory alone; a design that wrote on reads would corrupt the pixels. All sixteen raster codes run over all four S/D combinations at once, which catches a swapped index. Source-select replication is tested with bit 0 both set and clear, the protect mask is checked at both polarities, and the destination address is checked as it wraps above the memory depth.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_RASTER = 2'd1,
    OP_READ   = 2'd2,
    OP_PRIME  = 2'd3
  } op_e;

  localparam logic [2:0] MODE_VECTOR = 3'b010;
  localparam logic [2:0] MODE_BLIT   = 3'b100;

  localparam logic [2:0] IDX_MODE  = 3'd0;
  localparam logic [2:0] IDX_CTRL  = 3'd1;
  localparam logic [2:0] IDX_SRC   = 3'd2;
  localparam logic [2:0] IDX_ROP   = 3'd3;
  localparam logic [2:0] IDX_MASK  = 3'd4;
  localparam logic [2:0] IDX_DHI   = 3'd5;

  localparam int CTL_ROP_EN = 4;
  localparam int CTL_DESC   = 5;

  localparam logic [1:0] SRC_ONES = 2'b00;
  localparam logic [1:0] SRC_REPL = 2'b01;

endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int REG_W  = 8,
  parameter int ROP_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_data,
  output logic [REG_W-1:0]  mode_q,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [REG_W-1:0]  srcsel_q,
  output logic [REG_W-1:0]  dhi_q,
  output logic [ROP_W-1:0]  rop_q,
  output logic [WORD_W-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      ctrl_q   <= '0;
      srcsel_q <= '0;
      dhi_q    <= '0;
      rop_q    <= '0;
      mask_q   <= '0;
    end else if (wr_en) begin
      case (idx)
        IDX_MODE: mode_q   <= wdata[REG_W-1:0];
        IDX_CTRL: ctrl_q   <= wdata[REG_W-1:0];
        IDX_SRC:  srcsel_q <= wdata[REG_W-1:0];
        IDX_ROP:  rop_q    <= wdata[ROP_W-1:0];
        IDX_MASK: mask_q   <= wdata;
        IDX_DHI:  dhi_q    <= wdata[REG_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_MODE: rd_data = WORD_W'(mode_q);
      IDX_CTRL: rd_data = WORD_W'(ctrl_q);
      IDX_SRC:  rd_data = WORD_W'(srcsel_q);
      IDX_ROP:  rd_data = WORD_W'(rop_q);
      IDX_MASK: rd_data = mask_q;
      IDX_DHI:  rd_data = WORD_W'(dhi_q);
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/blit_plane_ram.sv
module blit_plane_ram #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic [ADDR_W-1:0] a_addr,
  output logic [WORD_W-1:0] a_q,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [WORD_W-1:0] b_din,
  output logic [WORD_W-1:0] b_q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_din;
      b_q <= mem[b_addr];
    end
  end

endmodule

// File: rtl/blit_funnel.sv
module blit_funnel #(
  parameter int WORD_W  = 16,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [WORD_W-1:0]  cur,
  input  logic [SHIFT_W-1:0] shamt,
  input  logic               desc,
  input  logic               bypass,
  output logic [WORD_W-1:0]  aligned
);

  logic [WORD_W-1:0]   held_q;
  logic [2*WORD_W-1:0] pair;

  always_ff @(posedge clk) begin
    if (rst)       held_q <= '0;
    else if (load) held_q <= cur;
  end

  always_comb begin
    pair    = desc ? {cur, held_q} : {held_q, cur};
    aligned = bypass ? cur : WORD_W'(pair >> shamt);
  end

endmodule

// File: rtl/blit_rop.sv
module blit_rop
  import blit_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ROP_W  = 4
) (
  input  logic [WORD_W-1:0] aligned,
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W-1:0] mask,
  input  logic [1:0]        srcsel,
  input  logic [ROP_W-1:0]  code,
  input  logic              rop_en,
  output logic [WORD_W-1:0] result
);

  logic [WORD_W-1:0] src;

  always_comb begin
    case (srcsel)
      SRC_ONES: src = '1;
      SRC_REPL: src = {WORD_W{aligned[0]}};
      default:  src = aligned;
    endcase
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    logic lut_bit;
    logic comb_bit;
    assign lut_bit   = code[{~src[i], ~dst[i]}];
    assign comb_bit  = rop_en ? lut_bit : src[i];
    assign result[i] = mask[i] ? dst[i] : comb_bit;
  end

endmodule

// File: rtl/mono_blit_engine.sv
module mono_blit_engine
  import blit_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 10,
  parameter int REG_W  = 8,
  parameter int ROP_W  = 4,
  parameter int DHI_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_regsel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              bus_stall,
  output logic              bus_rvalid,
  output logic [WORD_W-1:0] bus_rdata
);

  localparam int SHIFT_W = $clog2(WORD_W);

  logic [REG_W-1:0]  mode_q, ctrl_q, srcsel_q, dhi_q;
  logic [ROP_W-1:0]  rop_q;
  logic [WORD_W-1:0] mask_q, reg_rd_data;
  logic [2:0]        mode_code;
  logic              is_blit, is_vec;

  logic              busy_q, vec_q, rvalid_q;
  op_e               op_q;
  logic [ADDR_W-1:0] dst_q, dst_next;
  logic [WORD_W-1:0] rdata_q;

  logic accept, reg_wr_go, reg_rd_go, raster_go, plain_wr_go, mem_rd_go, wb_wr;
  logic ram_b_en, ram_b_we;
  logic [ADDR_W-1:0] ram_b_addr;
  logic [WORD_W-1:0] ram_b_din, ram_a_q, ram_b_q, aligned, rop_result;

  assign mode_code = mode_q[REG_W-1 -: 3];
  assign is_blit   = (mode_code == MODE_BLIT);
  assign is_vec    = (mode_code == MODE_VECTOR);

  assign accept      = bus_sel & ~busy_q;
  assign reg_wr_go   = accept & bus_regsel & bus_we;
  assign reg_rd_go   = accept & bus_regsel & ~bus_we;
  assign raster_go   = accept & ~bus_regsel & bus_we & (is_blit | is_vec);
  assign plain_wr_go = accept & ~bus_regsel & bus_we & ~(is_blit | is_vec);
  assign mem_rd_go   = accept & ~bus_regsel & ~bus_we;
  assign wb_wr       = busy_q & (op_q == OP_RASTER);

  if (ADDR_W <= WORD_W) begin : g_dst_low
    assign dst_next = bus_wdata[ADDR_W-1:0];
  end else begin : g_dst_high
    assign dst_next = {dhi_q[ADDR_W-WORD_W-1:0], bus_wdata};
  end

  blit_regs #(.WORD_W(WORD_W), .REG_W(REG_W), .ROP_W(ROP_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_go),
    .idx      (bus_addr[2:0]),
    .wdata    (bus_wdata),
    .rd_data  (reg_rd_data),
    .mode_q   (mode_q),
    .ctrl_q   (ctrl_q),
    .srcsel_q (srcsel_q),
    .dhi_q    (dhi_q),
    .rop_q    (rop_q),
    .mask_q   (mask_q)
  );

  assign ram_b_en   = raster_go | plain_wr_go | wb_wr;
  assign ram_b_we   = plain_wr_go | wb_wr;
  assign ram_b_addr = wb_wr ? dst_q : (raster_go ? dst_next : bus_addr);
  assign ram_b_din  = wb_wr ? rop_result : bus_wdata;

  blit_plane_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ram (
    .clk    (clk),
    .a_en   (raster_go | mem_rd_go),
    .a_addr (bus_addr),
    .a_q    (ram_a_q),
    .b_en   (ram_b_en),
    .b_we   (ram_b_we),
    .b_addr (ram_b_addr),
    .b_din  (ram_b_din),
    .b_q    (ram_b_q)
  );

  blit_funnel #(.WORD_W(WORD_W), .SHIFT_W(SHIFT_W)) u_funnel (
    .clk     (clk),
    .rst     (rst),
    .load    (busy_q & ((op_q == OP_RASTER) | (op_q == OP_PRIME))),
    .cur     (ram_a_q),
    .shamt   (mode_q[SHIFT_W-1:0]),
    .desc    (ctrl_q[CTL_DESC]),
    .bypass  (vec_q),
    .aligned (aligned)
  );

  blit_rop #(.WORD_W(WORD_W), .ROP_W(ROP_W)) u_rop (
    .aligned (aligned),
    .dst     (ram_b_q),
    .mask    (mask_q),
    .srcsel  (srcsel_q[REG_W-1 -: 2]),
    .code    (rop_q),
    .rop_en  (ctrl_q[CTL_ROP_EN]),
    .result  (rop_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      op_q     <= OP_IDLE;
      vec_q    <= 1'b0;
      dst_q    <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= reg_rd_go | (busy_q & ((op_q == OP_READ) | (op_q == OP_PRIME)));
      if (reg_rd_go) rdata_q <= reg_rd_data;
      else if (busy_q & ((op_q == OP_READ) | (op_q == OP_PRIME))) rdata_q <= ram_a_q;

      if (busy_q) begin
        busy_q <= 1'b0;
        op_q   <= OP_IDLE;
      end else if (raster_go) begin
        busy_q <= 1'b1;
        op_q   <= OP_RASTER;
        vec_q  <= is_vec;
        dst_q  <= dst_next;
      end else if (mem_rd_go) begin
        busy_q <= 1'b1;
        op_q   <= is_blit ? OP_PRIME : OP_READ;
      end
    end
  end

  assign bus_stall  = busy_q;
  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;

endmodule

// File: rtl/blit_checker.sv
module blit_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_sel,
  input logic       bus_regsel,
  input logic       bus_we,
  input logic       bus_stall,
  input logic       bus_rvalid,
  input logic [2:0] mode_code,
  input logic [1:0] op,
  input logic       ram_we
);

  logic raster_mode;
  assign raster_mode = (mode_code == 3'b100) || (mode_code == 3'b010);

  p_raster_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_stall && !bus_regsel && bus_we && raster_mode) |=> bus_stall);

  p_stall_single_r4: assert property (@(posedge clk) disable iff (rst)
    bus_stall |=> !bus_stall);

  p_wb_only_raster_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_stall && ram_we) |-> (op == 2'd1));

  p_plain_write_free_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_stall && !bus_regsel && bus_we && !raster_mode) |=> !bus_stall);

  p_mem_read_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_stall && !bus_regsel && !bus_we) |=> (bus_stall && !bus_rvalid));

  p_rvalid_free_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> !bus_stall);

  p_reg_read_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_stall && bus_regsel && !bus_we) |=> bus_rvalid);

  p_prime_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_stall && op == 2'd3) |-> !ram_we);

endmodule

bind mono_blit_engine blit_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_regsel (bus_regsel),
  .bus_we     (bus_we),
  .bus_stall  (bus_stall),
  .bus_rvalid (bus_rvalid),
  .mode_code  (mode_code),
  .op         (op_q),
  .ram_we     (ram_b_we)
);

// File: tb/sim_mono_blit_engine.sv
module sim_mono_blit_engine;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_regsel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_stall, bus_rvalid;
  logic [15:0] bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [15:0] mdl [1024];
  logic [15:0] held_m = '0;
  logic [7:0]  c_mode = '0, c_ctrl = '0, c_sel = '0, c_dhi = '0;
  logic [3:0]  c_rop = '0;
  logic [15:0] c_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mono_blit_engine u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_regsel(bus_regsel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_stall(bus_stall),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] rop_ref(input logic [3:0] c, input logic [15:0] s, input logic [15:0] d);
    case (c)
      4'h0: return 16'h0000;
      4'h1: return s & d;
      4'h2: return s & ~d;
      4'h3: return s;
      4'h4: return ~s & d;
      4'h5: return d;
      4'h6: return s ^ d;
      4'h7: return s | d;
      4'h8: return ~(s | d);
      4'h9: return ~(s ^ d);
      4'hA: return ~d;
      4'hB: return s | ~d;
      4'hC: return ~s;
      4'hD: return ~s | d;
      4'hE: return ~(s & d);
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] step_ref(input logic [15:0] held, input logic [15:0] cur, input logic [15:0] d);
    logic [31:0] pair;
    logic [15:0] al, s, r;
    if (c_mode[7:5] == 3'b010) al = cur;
    else begin
      pair = c_ctrl[5] ? {cur, held} : {held, cur};
      pair = pair >> c_mode[3:0];
      al = pair[15:0];
    end
    case (c_sel[7:6])
      2'b00:   s = 16'hFFFF;
      2'b01:   s = {16{al[0]}};
      default: s = al;
    endcase
    r = c_ctrl[4] ? rop_ref(c_rop, s, d) : s;
    return (c_mask & d) | (~c_mask & r);
  endfunction

  task automatic idle();
    bus_sel = 1'b0; bus_we = 1'b0; bus_regsel = 1'b0;
  endtask

  task automatic start(input logic rs, input logic we, input int a, input logic [15:0] d);
    @(negedge clk);
    while (bus_stall) @(negedge clk);
    bus_sel = 1'b1; bus_regsel = rs; bus_we = we; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic get_rd(output logic [15:0] d, input string rq);
    bit got = 0;
    d = 'x;
    for (int k = 0; k < 4; k++) begin
      if (bus_rvalid) begin d = bus_rdata; got = 1; break; end
      @(negedge clk);
    end
    if (!got) chk({rq, " read-valid"}, 16'h0, 16'h1);
  endtask

  task automatic cfg(input int idx, input logic [15:0] v);
    start(1'b1, 1'b1, idx, v);
    case (idx)
      0: c_mode = v[7:0];
      1: c_ctrl = v[7:0];
      2: c_sel  = v[7:0];
      3: c_rop  = v[3:0];
      4: c_mask = v;
      default: c_dhi = v[7:0];
    endcase
  endtask

  task automatic reg_rd(input int idx, output logic [15:0] d);
    start(1'b1, 1'b0, idx, 16'h0);
    get_rd(d, "R3");
  endtask

  task automatic mem_rd(input int a, output logic [15:0] d, input string rq);
    start(1'b0, 1'b0, a, 16'h0);
    chk({rq, " read stall"}, {15'b0, bus_stall}, 16'h1);
    get_rd(d, rq);
  endtask

  task automatic preload(input int a, input logic [15:0] v);
    start(1'b0, 1'b1, a, v);
    chk("R2 plain write no stall", {15'b0, bus_stall}, 16'h0);
    mdl[a] = v;
  endtask

  task automatic verify(input int a, input string rq);
    logic [15:0] d;
    mem_rd(a, d, rq);
    chk(rq, d, mdl[a]);
  endtask

  task automatic blit(input int src, input logic [15:0] dw, input string rq);
    logic [17:0] full;
    int di;
    logic [15:0] cur, exp;
    full = {c_dhi[1:0], dw};
    di = int'(full[9:0]);
    cur = mdl[src];
    exp = step_ref(held_m, cur, mdl[di]);
    start(1'b0, 1'b1, src, dw);
    chk({rq, " R4 stall raised"}, {15'b0, bus_stall}, 16'h1);
    @(negedge clk);
    chk({rq, " R4 stall released"}, {15'b0, bus_stall}, 16'h0);
    mdl[di] = exp;
    held_m = cur;
  endtask

  task automatic normal_mode();
    cfg(0, 16'h00E0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 stall at reset", {15'b0, bus_stall}, 16'h0);
    chk("R1 rvalid at reset", {15'b0, bus_rvalid}, 16'h0);
    for (int i = 0; i < 6; i++) begin
      reg_rd(i, d);
      chk("R1 register reset value", d, 16'h0000);
    end
  endtask

  task automatic t_regs();
    logic [15:0] d;
    cfg(0, 16'hFFA7); reg_rd(0, d); chk("R3 mode reg width", d, 16'h00A7);
    cfg(1, 16'h005A); reg_rd(1, d); chk("R3 control reg", d, 16'h005A);
    cfg(2, 16'h12C3); reg_rd(2, d); chk("R3 source select reg", d, 16'h00C3);
    cfg(3, 16'h1234); reg_rd(3, d); chk("R3 rop reg width", d, 16'h0004);
    cfg(4, 16'hBEEF); reg_rd(4, d); chk("R3 mask reg", d, 16'hBEEF);
    cfg(5, 16'h00E1); reg_rd(5, d); chk("R3 dest high reg", d, 16'h00E1);
    cfg(0, 16'h0000); cfg(1, 16'h0010); cfg(2, 16'h00C0);
    cfg(3, 16'h0003); cfg(4, 16'h0000); cfg(5, 16'h0000);
  endtask

  task automatic t_normal();
    preload(5, 16'h1357);
    verify(5, "R2 normal at mode 000");
    normal_mode();
    preload(6, 16'hFACE); preload(7, 16'h0001);
    verify(6, "R2 normal readback"); verify(7, "R2 normal readback");
    cfg(0, 16'h0060);
    preload(8, 16'h2468);
    verify(8, "R12 mode 011 is plain");
    normal_mode();
  endtask

  task automatic t_held_reset();
    preload(10, 16'h8421); preload(20, 16'h0000);
    cfg(0, 16'h0084);
    blit(10, 16'd20, "R1 held zero");
    normal_mode();
    verify(20, "R1 held word zero after reset");
    chk("R1 literal", mdl[20], 16'h0842);
  endtask

  task automatic t_rop();
    preload(300, 16'hCCCC);
    for (int c = 0; c < 17; c++) preload(400 + c, 16'hAAAA);
    cfg(0, 16'h0080); cfg(1, 16'h0010); cfg(2, 16'h00C0); cfg(4, 16'h0000);
    for (int c = 0; c < 16; c++) begin
      cfg(3, 16'(c));
      blit(300, 16'(400 + c), "R5");
    end
    normal_mode();
    for (int c = 0; c < 16; c++) verify(400 + c, "R5 rop code");
    chk("R5 xor literal", mdl[406], 16'h6666);
    chk("R5 s-and-not-d literal", mdl[402], 16'h4444);
    cfg(0, 16'h0080); cfg(1, 16'h0000); cfg(3, 16'h0000);
    blit(300, 16'd416, "R6");
    normal_mode();
    verify(416, "R6 rop disabled copies source");
    chk("R6 literal", mdl[416], 16'hCCCC);
    cfg(1, 16'h0010); cfg(3, 16'h0003);
  endtask

  task automatic t_srcsel();
    preload(500, 16'h0001); preload(501, 16'hFFFE);
    for (int i = 0; i < 4; i++) preload(510 + i, 16'h5555);
    cfg(0, 16'h0080);
    cfg(2, 16'h0000); blit(500, 16'd510, "R7 ones");
    cfg(2, 16'h0040); blit(500, 16'd511, "R7 repl1"); blit(501, 16'd512, "R7 repl0");
    cfg(2, 16'h0080); blit(501, 16'd513, "R7 code10");
    normal_mode();
    verify(510, "R7 all ones"); chk("R7 ones literal", mdl[510], 16'hFFFF);
    verify(511, "R7 replicate set"); chk("R7 repl literal", mdl[511], 16'hFFFF);
    verify(512, "R7 replicate clear"); chk("R7 repl0 literal", mdl[512], 16'h0000);
    verify(513, "R7 code 10 passes word");
    cfg(2, 16'h00C0);
  endtask

  task automatic t_mask();
    preload(520, 16'h1234); preload(521, 16'hABCD); preload(522, 16'h0F0F);
    cfg(0, 16'h0080); cfg(4, 16'hF00F);
    blit(520, 16'd521, "R8 mask");
    cfg(4, 16'hFFFF);
    blit(520, 16'd522, "R8 full mask");
    normal_mode();
    verify(521, "R8 partial mask"); chk("R8 literal", mdl[521], 16'hA23D);
    verify(522, "R8 full mask keeps dest"); chk("R8 full literal", mdl[522], 16'h0F0F);
    cfg(4, 16'h0000);
  endtask

  task automatic t_funnel();
    logic [15:0] d;
    preload(600, 16'hF00F); preload(601, 16'h1234); preload(602, 16'h7777);
    for (int i = 0; i < 6; i++) preload(610 + i, 16'h0000);
    cfg(0, 16'h0084);
    mem_rd(600, d, "R11 prime"); chk("R11 prime returns word", d, 16'hF00F); held_m = 16'hF00F;
    blit(601, 16'd610, "R9 shift4");
    cfg(0, 16'h0094);
    blit(600, 16'd611, "R9 shift bit4 ignored");
    cfg(0, 16'h008F);
    mem_rd(602, d, "R11 prime2"); held_m = 16'h7777;
    blit(601, 16'd612, "R9 shift15");
    normal_mode();
    mem_rd(600, d, "R11 normal read");
    cfg(0, 16'h0083);
    blit(600, 16'd613, "R11 normal read left held");
    cfg(1, 16'h0030); cfg(0, 16'h0084);
    mem_rd(601, d, "R10 prime"); held_m = 16'h1234;
    blit(600, 16'd614, "R10 desc shift4");
    cfg(0, 16'h0080);
    blit(601, 16'd615, "R10 desc shift0");
    cfg(1, 16'h0010);
    normal_mode();
    verify(610, "R9 ascending shift 4"); chk("R9 literal", mdl[610], 16'hF123);
    verify(611, "R9 shift field bit 4 ignored");
    verify(612, "R9 shift 15");
    verify(613, "R11 held unchanged by normal read");
    verify(614, "R10 descending shift 4");
    verify(615, "R10 descending shift 0 gives held");
    chk("R10 literal", mdl[615], 16'hF00F);
    verify(600, "R11 prime writes nothing");
    verify(602, "R11 prime writes nothing");
  endtask

  task automatic t_vector();
    logic [15:0] d;
    preload(620, 16'h0000); preload(621, 16'h1111);
    cfg(0, 16'h0045);
    blit(601, 16'd620, "R12 vector");
    mem_rd(602, d, "R12 vector read"); chk("R12 vector read data", d, 16'h7777);
    cfg(2, 16'h0000); cfg(4, 16'h00FF);
    blit(601, 16'd621, "R12 vector ones");
    normal_mode();
    verify(620, "R12 vector no shift"); chk("R12 literal", mdl[620], 16'h1234);
    verify(621, "R12 vector with ones and mask"); chk("R12 ones literal", mdl[621], 16'hFF11);
    cfg(2, 16'h00C0); cfg(4, 16'h0000);
  endtask

  task automatic t_dest_high();
    preload(291, 16'h0000); preload(292, 16'h0000);
    cfg(5, 16'h000E); cfg(0, 16'h0080);
    blit(601, 16'h0123, "R4 dest high");
    blit(600, 16'h0524, "R4 dest wrap");
    normal_mode();
    verify(291, "R4 destination low bits"); verify(292, "R4 destination wraps");
    cfg(5, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_normal();
    t_held_reset();
    t_rop();
    t_srcsel();
    t_mask();
    t_funnel();
    t_vector();
    t_dest_high();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule